// File: doc/BRIEF.md
# Quadtree Resolution Map Controller

This block holds the sampling plan for a camera that compresses at the sensor. Each frame is split into tiles of 4x4 base blocks. Within a tile, a region is sampled at one of three levels:
- level 0: a single base block;
- level 1: a 2x2 group of base blocks, taken as one block decimated by 2;
- level 2: the whole tile, taken as one block decimated by 4.

Legal layouts are quadtrees only. A coarser node always replaces exactly four sibling nodes of the same size.

During a frame, an upstream quality predictor sends one decision per region over a valid/ready handshake. A decision asks to refine, coarsen or hold the region. The predictor asks for finer sampling where its predicted quality would fall below the target. Decisions are only stored while the frame runs.

When a frame-end strobe arrives, all pending decisions are applied in a single commit. The commit builds the map for the next frame, and the pending decisions are then cleared. One cycle after the commit, the block publishes the number of coded blocks the next frame will carry, with a one-cycle valid pulse, for a downstream voltage/frequency controller. Every leaf node counts as one block, whatever its size.

A combinational read port returns the level in force at any base-block position.

Top module: `qtm_resmap_ctrl`

## Requirements
- R1: After reset, every base-block position of every tile reads level 0. `block_count` equals 16 times NUM_TILES, and `count_valid` is low.
- R2: At a commit, a 2x2 group of level-0 blocks becomes one level-1 node if all four of its positions hold the coarsen code 01.
- R3: A 2x2 group in which fewer than four positions hold 01 keeps its current levels.
- R4: At a commit, a tile becomes one level-2 node when two conditions hold: all four of its 2x2 groups are level-1 nodes, and each group's anchor holds 01. The anchor is the group's lowest-numbered position.
- R5: The refine code 10 at the anchor of a merged node splits it at a commit. A level-2 node (anchor position 0) becomes four level-1 nodes. A level-1 node becomes four level-0 blocks.
- R6: The following have no effect on the map:
  - code 10 on a level-0 block;
  - code 01 on a level-2 node;
  - code 11, which acts as hold (00);
  - any code at a non-anchor position of a merged node.
- R7: The map changes only at a commit, and each node moves by at most one level per commit. A later decision for the same position replaces an earlier one within a frame. All pending decisions return to hold after a commit.
- R8: Suppose `frame_end` is sampled high at clock edge k. The new map is readable after edge k. After edge k+1, `block_count` holds the leaf count of that map for exactly one cycle of `count_valid`. The count changes at no other time.
- R9: `dec_ready` is high except in a cycle where `frame_end` is high. A decision offered in such a cycle is dropped.
- R10: `rd_level` returns 0, 1 or 2 for the tile `rd_tile` at position `rd_pos`, where `rd_pos[3:2]` is the row and `rd_pos[1:0]` the column within the tile.
- R11: Decisions addressed to one tile never change another tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decision offered |
| dec_ready | output | 1 | Decision can be taken this cycle |
| dec_tile | input | TILE_W | Tile the decision addresses |
| dec_pos | input | 4 | Base-block position {row, col} inside the tile |
| dec_code | input | 2 | 00 hold, 01 coarsen, 10 refine, 11 hold |
| frame_end | input | 1 | Frame boundary strobe; triggers the commit |
| rd_tile | input | TILE_W | Read port tile index |
| rd_pos | input | 4 | Read port base-block position |
| rd_level | output | 2 | Level in force at the read position |
| block_count | output | CNT_W | Coded blocks in the next frame |
| count_valid | output | 1 | One-cycle pulse when block_count is new |

## Verification
A corrupted node record shows up in two places within one cycle of the commit that wrote it. The read port shows an illegal or unexpected level pattern over a 2x2 group or a tile, and the published count is off by 3, 12 or 15. A decision that lands in the wrong slot, or a pending buffer that is not cleared, appears one frame later as a merge or split that the predictor never asked for. The bench therefore scans the whole map after every commit and compares every count pulse against its own leaf count.

// File: rtl/qtm_pkg.sv
package qtm_pkg;

  localparam int BLK_PER_TILE = 16;
  localparam int POS_W        = 4;

  localparam logic [1:0] LVL_BASE = 2'd0;
  localparam logic [1:0] LVL_QUAD = 2'd1;
  localparam logic [1:0] LVL_TILE = 2'd2;

  typedef enum logic [1:0] {
    DEC_KEEP  = 2'b00,
    DEC_LOWER = 2'b01,
    DEC_RAISE = 2'b10,
    DEC_HOLD  = 2'b11
  } dec_code_e;

  // whole: tile is one level-2 node (quad is then all ones)
  // quad[k]: 2x2 group k is one level-1 node
  typedef struct packed {
    logic       whole;
    logic [3:0] quad;
  } tile_map_t;

  typedef logic [BLK_PER_TILE-1:0][1:0] tile_dec_t;

  // group index: {row half, col half}
  function automatic logic [1:0] group_of(input logic [POS_W-1:0] pos);
    return {pos[3], pos[1]};
  endfunction

  function automatic logic [POS_W-1:0] anchor_pos(input logic [1:0] k);
    return {k[1], 1'b0, k[0], 1'b0};
  endfunction

  function automatic logic [POS_W-1:0] member_pos(input logic [1:0] k,
                                                  input logic [1:0] b);
    return {k[1], b[1], k[0], b[0]};
  endfunction

  function automatic logic [1:0] level_at(input tile_map_t m,
                                          input logic [POS_W-1:0] pos);
    if (m.whole)                 return LVL_TILE;
    else if (m.quad[group_of(pos)]) return LVL_QUAD;
    else                         return LVL_BASE;
  endfunction

  function automatic logic [4:0] leaf_count(input tile_map_t m);
    logic [4:0] n;
    if (m.whole) return 5'd1;
    n = '0;
    for (int k = 0; k < 4; k++) n = n + (m.quad[k] ? 5'd1 : 5'd4);
    return n;
  endfunction

endpackage

// File: rtl/qtm_decision_buf.sv
module qtm_decision_buf
  import qtm_pkg::*;
#(
  parameter int NUM_TILES = 4,
  parameter int TILE_W    = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [TILE_W-1:0]        wr_tile,
  input  logic [POS_W-1:0]         wr_pos,
  input  logic [1:0]               wr_code,
  input  logic                     clear,
  output tile_dec_t [NUM_TILES-1:0] dec_o
);

  tile_dec_t [NUM_TILES-1:0] pend_q;

  // R7: last write wins; cleared to hold on commit
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      pend_q <= '0;
    end else if (wr_en) begin
      pend_q[wr_tile][wr_pos] <= wr_code;
    end
  end

  assign dec_o = pend_q;

endmodule

// File: rtl/qtm_tile_next.sv
module qtm_tile_next
  import qtm_pkg::*;
(
  input  tile_map_t  cur_i,
  input  tile_dec_t  dec_i,
  output tile_map_t  nxt_o,
  output logic [3:0] l1_merge_o,
  output logic [3:0] l1_split_o,
  output logic       l2_merge_o,
  output logic       l2_split_o
);

  logic [3:0] grp_all_lower;
  logic [3:0] anchor_lower;
  logic [3:0] anchor_raise;

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      grp_all_lower[k] = 1'b1;
      for (int b = 0; b < 4; b++) begin
        if (dec_i[member_pos(2'(k), 2'(b))] != DEC_LOWER) grp_all_lower[k] = 1'b0;
      end
      anchor_lower[k] = (dec_i[anchor_pos(2'(k))] == DEC_LOWER);
      anchor_raise[k] = (dec_i[anchor_pos(2'(k))] == DEC_RAISE);
    end
  end

  always_comb begin
    nxt_o      = cur_i;
    l1_merge_o = '0;
    l1_split_o = '0;
    l2_merge_o = 1'b0;
    l2_split_o = 1'b0;
    if (cur_i.whole) begin
      // R5 split of a tile node; a coarsen request is ignored (R6)
      if (anchor_raise[0]) begin
        l2_split_o  = 1'b1;
        nxt_o.whole = 1'b0;
        nxt_o.quad  = 4'hF;
      end
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (cur_i.quad[k]) begin
          if (anchor_raise[k]) begin
            l1_split_o[k] = 1'b1;
            nxt_o.quad[k] = 1'b0;
          end
        end else if (grp_all_lower[k]) begin
          l1_merge_o[k] = 1'b1;
          nxt_o.quad[k] = 1'b1;
        end
      end
      if ((&cur_i.quad) && (&anchor_lower)) begin
        l2_merge_o  = 1'b1;
        nxt_o.whole = 1'b1;
        nxt_o.quad  = 4'hF;
      end
    end
  end

endmodule

// File: rtl/qtm_block_counter.sv
module qtm_block_counter
  import qtm_pkg::*;
#(
  parameter int NUM_TILES = 4,
  parameter int CNT_W     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  tile_map_t [NUM_TILES-1:0] maps_i,
  output logic [CNT_W-1:0]          count_o,
  output logic                      valid_o
);

  localparam int MAX_BLOCKS = NUM_TILES * BLK_PER_TILE;

  logic [CNT_W-1:0] sum;

  always_comb begin
    sum = '0;
    for (int t = 0; t < NUM_TILES; t++) sum = sum + CNT_W'(leaf_count(maps_i[t]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= CNT_W'(MAX_BLOCKS);
      valid_o <= 1'b0;
    end else begin
      valid_o <= start;
      if (start) count_o <= sum;
    end
  end

endmodule

// File: rtl/qtm_resmap_ctrl.sv
module qtm_resmap_ctrl
  import qtm_pkg::*;
#(
  parameter  int NUM_TILES = 4,
  localparam int TILE_W    = (NUM_TILES > 1) ? $clog2(NUM_TILES) : 1,
  localparam int CNT_W     = $clog2(NUM_TILES * 16 + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  output logic              dec_ready,
  input  logic [TILE_W-1:0] dec_tile,
  input  logic [3:0]        dec_pos,
  input  logic [1:0]        dec_code,
  input  logic              frame_end,
  input  logic [TILE_W-1:0] rd_tile,
  input  logic [3:0]        rd_pos,
  output logic [1:0]        rd_level,
  output logic [CNT_W-1:0]  block_count,
  output logic              count_valid
);

  localparam int MAX_BLOCKS = NUM_TILES * BLK_PER_TILE;

  tile_map_t [NUM_TILES-1:0] map_q;
  tile_map_t [NUM_TILES-1:0] map_nxt;
  tile_dec_t [NUM_TILES-1:0] dec_all;

  logic       commit;
  logic       dec_accept;
  logic       count_start;
  logic [3:0] ev_l1_merge [NUM_TILES];
  logic [3:0] ev_l1_split [NUM_TILES];
  logic       ev_l2_merge [NUM_TILES];
  logic       ev_l2_split [NUM_TILES];

  // R9: no decision is taken in the commit cycle
  assign commit     = frame_end;
  assign dec_ready  = !frame_end;
  assign dec_accept = dec_valid && dec_ready && (int'(dec_tile) < NUM_TILES);

  qtm_decision_buf #(.NUM_TILES(NUM_TILES), .TILE_W(TILE_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (dec_accept),
    .wr_tile (dec_tile),
    .wr_pos  (dec_pos),
    .wr_code (dec_code),
    .clear   (commit),
    .dec_o   (dec_all)
  );

  // R11: one independent update per tile
  for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
    qtm_tile_next u_nx (
      .cur_i      (map_q[t]),
      .dec_i      (dec_all[t]),
      .nxt_o      (map_nxt[t]),
      .l1_merge_o (ev_l1_merge[t]),
      .l1_split_o (ev_l1_split[t]),
      .l2_merge_o (ev_l2_merge[t]),
      .l2_split_o (ev_l2_split[t])
    );

    // R4 node shape: a tile node always covers four group nodes
    shape_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      map_q[t].whole |-> (map_q[t].quad == 4'hF));

    // R2
    l1_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (ev_l1_merge[t] != 4'b0)) |=>
        ((map_q[t].quad & $past(ev_l1_merge[t])) == $past(ev_l1_merge[t])));

    // R5
    l1_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (ev_l1_split[t] != 4'b0)) |=>
        ((map_q[t].quad & $past(ev_l1_split[t])) == 4'b0));

    // R4
    l2_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && ev_l2_merge[t]) |=> map_q[t].whole);

    // R5
    l2_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && ev_l2_split[t]) |=> (!map_q[t].whole && (map_q[t].quad == 4'hF)));

    // R6
    l2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && map_q[t].whole && !ev_l2_split[t]) |=> map_q[t].whole);
  end

  // R1 reset to full resolution; R7 map moves only at a commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q       <= '0;
      count_start <= 1'b0;
    end else begin
      count_start <= commit;
      if (commit) map_q <= map_nxt;
    end
  end

  qtm_block_counter #(.NUM_TILES(NUM_TILES), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (count_start),
    .maps_i  (map_q),
    .count_o (block_count),
    .valid_o (count_valid)
  );

  // R10
  assign rd_level = (int'(rd_tile) < NUM_TILES) ? level_at(map_q[rd_tile], rd_pos) : LVL_BASE;

  // R7
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(map_q));

  // R8
  count_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ##2 count_valid);

  // R8
  count_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(block_count) |-> count_valid);

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (block_count <= CNT_W'(MAX_BLOCKS)) && (block_count >= CNT_W'(NUM_TILES)));

endmodule

// File: tb/tb_qtm_resmap_ctrl.sv
module tb_qtm_resmap_ctrl;

  localparam int NT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dec_valid;
  logic       dec_ready;
  logic [1:0] dec_tile;
  logic [3:0] dec_pos;
  logic [1:0] dec_code;
  logic       frame_end;
  logic [1:0] rd_tile;
  logic [3:0] rd_pos;
  logic [1:0] rd_level;
  logic [6:0] block_count;
  logic       count_valid;

  always #10 clk = ~clk;

  qtm_resmap_ctrl #(.NUM_TILES(NT)) dut (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_tile(dec_tile), .dec_pos(dec_pos), .dec_code(dec_code),
    .frame_end(frame_end), .rd_tile(rd_tile), .rd_pos(rd_pos),
    .rd_level(rd_level), .block_count(block_count), .count_valid(count_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int lvl  [NT][16];
  int pend [NT][16];
  int exp_q [$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int anchor(input int k);
    return 8 * (k >> 1) + 2 * (k & 1);
  endfunction

  function automatic int basep(input int k, input int b);
    return (2 * (k >> 1) + (b >> 1)) * 4 + 2 * (k & 1) + (b & 1);
  endfunction

  function automatic int model_count();
    int n0 = 0, n1 = 0, n2 = 0;
    for (int t = 0; t < NT; t++)
      for (int p = 0; p < 16; p++) begin
        if (lvl[t][p] == 0) n0++;
        else if (lvl[t][p] == 1) n1++;
        else n2++;
      end
    return n0 + n1 / 4 + n2 / 16;
  endfunction

  task automatic model_commit();
    int old [NT][16];
    old = lvl;
    for (int t = 0; t < NT; t++) begin
      if (old[t][0] == 2) begin
        if (pend[t][0] == 2) for (int p = 0; p < 16; p++) lvl[t][p] = 1;
      end else begin
        int grp1 = 0;
        int alow = 0;
        for (int k = 0; k < 4; k++) begin
          if (old[t][anchor(k)] == 1) begin
            grp1++;
            if (pend[t][anchor(k)] == 1) alow++;
            if (pend[t][anchor(k)] == 2)
              for (int b = 0; b < 4; b++) lvl[t][basep(k, b)] = 0;
          end else begin
            int low = 0;
            for (int b = 0; b < 4; b++) if (pend[t][basep(k, b)] == 1) low++;
            if (low == 4) for (int b = 0; b < 4; b++) lvl[t][basep(k, b)] = 1;
          end
        end
        if (grp1 == 4 && alow == 4) for (int p = 0; p < 16; p++) lvl[t][p] = 2;
      end
      for (int p = 0; p < 16; p++) pend[t][p] = 0;
    end
  endtask

  // monitor: pops expected counts as pulses appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && count_valid === 1'b1) begin
      if (exp_q.size() == 0) check(1'b0, "R8 unexpected count pulse", 1, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(block_count) == e, "R8 block_count", int'(block_count), e);
      end
    end
  end

  task automatic check_map(input string req);
    for (int t = 0; t < NT; t++)
      for (int p = 0; p < 16; p++) begin
        rd_tile = 2'(t);
        rd_pos  = 4'(p);
        #1;
        check(int'(rd_level) == lvl[t][p], req, int'(rd_level), lvl[t][p]);
      end
  endtask

  task automatic send(input int t, input int p, input int code);
    @(negedge clk);
    dec_valid = 1'b1;
    dec_tile  = 2'(t);
    dec_pos   = 4'(p);
    dec_code  = 2'(code);
    #1;
    check(dec_ready === 1'b1, "R9 ready outside commit", int'(dec_ready), 1);
    @(negedge clk);
    dec_valid = 1'b0;
    pend[t][p] = code;
  endtask

  task automatic send_group(input int t, input int k, input int code);
    for (int b = 0; b < 4; b++) send(t, basep(k, b), code);
  endtask

  task automatic commit(input bit stray, input int st, input int sp);
    model_commit();
    exp_q.push_back(model_count());
    @(negedge clk);
    frame_end = 1'b1;
    if (stray) begin
      dec_valid = 1'b1;
      dec_tile  = 2'(st);
      dec_pos   = 4'(sp);
      dec_code  = 2'b01;
    end
    #1;
    check(dec_ready === 1'b0, "R9 ready low at commit", int'(dec_ready), 0);
    @(negedge clk);
    frame_end = 1'b0;
    dec_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check(count_valid === 1'b0, "R8 pulse is one cycle", int'(count_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dec_valid = 1'b0; dec_tile = '0; dec_pos = '0; dec_code = '0;
    frame_end = 1'b0; rd_tile = '0; rd_pos = '0;
    for (int t = 0; t < NT; t++)
      for (int p = 0; p < 16; p++) begin lvl[t][p] = 0; pend[t][p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(int'(block_count) == 64, "R1 reset count", int'(block_count), 64);
    check(count_valid === 1'b0, "R1 reset count_valid", int'(count_valid), 0);
    check_map("R1 reset map");

    // R2 full merge, R3 partial, R6 base refine and code 11
    send_group(0, 0, 1);
    for (int b = 0; b < 3; b++) send(1, basep(3, b), 1);
    send(1, basep(3, 3), 0);
    send(2, 5, 2);
    send_group(0, 1, 3);
    check_map("R7 map unchanged before commit");
    commit(1'b0, 0, 0);
    check_map("R2 R3 R6 R11 map after commit");

    // R2 remaining groups; R7 last write wins on tile 3
    send_group(0, 1, 1);
    send_group(0, 2, 1);
    send_group(0, 3, 1);
    send_group(3, 0, 1);
    send(3, 0, 0);
    commit(1'b0, 0, 0);
    check_map("R2 R7 map after commit");

    // R4 tile merge, plus another group merge on tile 1
    for (int k = 0; k < 4; k++) send(0, anchor(k), 1);
    send_group(1, 0, 1);
    commit(1'b0, 0, 0);
    check_map("R4 map after commit");

    // R6 coarsen at level 2, non-anchor decisions on merged nodes
    send(0, 0, 1);
    send(0, 5, 2);
    send(1, 1, 2);
    commit(1'b0, 0, 0);
    check_map("R6 map after commit");

    // R5 splits of a tile node and a group node
    send(0, 0, 2);
    send(1, 0, 2);
    commit(1'b0, 0, 0);
    check_map("R5 map after commit");

    // R9 decision offered during commit is dropped
    for (int b = 0; b < 3; b++) send(3, basep(2, b), 1);
    commit(1'b1, 3, basep(2, 3));
    check_map("R9 map after dropped decision");

    // R7 pending decisions were cleared by the commit
    send(3, basep(2, 3), 1);
    commit(1'b0, 0, 0);
    check_map("R7 map after clear");

    // R4 blocked by one refine anchor, R5 that group splits
    send(0, anchor(0), 1);
    send(0, anchor(1), 2);
    send(0, anchor(2), 1);
    send(0, anchor(3), 1);
    commit(1'b0, 0, 0);
    check_map("R4 R5 map after mixed anchors");

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R8 all count pulses seen", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule